// File: doc/BRIEF.md
# Packet Stream to Enable/Error Byte Framer

This block takes a byte-wide internal packet stream and drives it onto a framed byte interface of the kind used for packet FIFO transfer between two chips. The input is a valid/ready stream. Each byte carries a start-of-packet marker, an end-of-packet marker and an error marker. The output is an 8-bit data bus with an enable line and an error line. All three outputs are registered and change on the rising clock edge, so the far side samples one byte per clock.

Enable is high exactly on the bytes of a packet. The first enabled byte is the start of the packet and the last enabled byte is its end. The error line may only be high while enable is high. Once the error line is raised inside a frame, it stays high on every later byte until the frame ends. After each packet the block forces a configurable number of idle cycles. During these cycles it withholds ready, so back-to-back packets always stay separable on the wire.

Top module: `gmiitx_top`

## Requirements
- R1: While reset is held and on the first cycle after it, tx_en, tx_er and tx_data are all zero and s_ready is 1.
- R2: A byte accepted (s_valid and s_ready both 1) with s_sop=1 while no frame is open appears on tx_data with tx_en=1 on the next cycle, and it opens a frame.
- R3: Every byte accepted while a frame is open appears on tx_data with tx_en=1 exactly one cycle after acceptance, in input order, one byte per clock.
- R4: Accepting a framed byte with s_eop=1 closes the frame. s_ready is then 0 for the next IDLE_GAP cycles, so tx_en stays 0 for at least IDLE_GAP cycles before the next packet.
- R5: A byte is taken only when s_valid and s_ready are both 1. A cycle with no accepted byte yields tx_en=0 on the next cycle, and a byte offered while s_ready is 0 is taken later, unchanged.
- R6: tx_er is 1 only in cycles where tx_en is 1.
- R7: Once tx_er is 1 within a frame, it is 1 on every later enabled byte of that frame, through the end-of-packet byte.
- R8: A byte accepted with s_err=1 shows tx_er=1 on that same output byte, including when it is the end-of-packet byte.
- R9: tx_data is all zeros whenever tx_en is 0.
- R10: A byte accepted while no frame is open and s_sop=0 is discarded. tx_en stays 0, no frame opens, and its s_eop starts no idle gap.
- R11: The held error clears when a frame closes. The next packet shows tx_er=0 unless one of its own bytes is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input byte present |
| s_ready | output | 1 | Block can take a byte this cycle |
| s_data | input | BYTE_W | Input byte |
| s_sop | input | 1 | Input byte is the first of a packet |
| s_eop | input | 1 | Input byte is the last of a packet |
| s_err | input | 1 | Input byte marks the packet as errored |
| tx_data | output | BYTE_W | Framed output byte, zero when idle |
| tx_en | output | 1 | Output byte belongs to a packet |
| tx_er | output | 1 | Packet carrying this byte is errored |

## Verification
Each byte accepted at a rising edge shows up on tx_data, tx_en and tx_er after exactly one register stage, at the next edge. s_ready drops in the cycle right after an end-of-packet byte is taken and returns IDLE_GAP cycles later. The bench drives inputs on the falling edge. At the following falling edge it compares all outputs with a behavioural model that has been advanced by one accepted-byte step. That comparison lands one full register stage after the stimulus and never shares an edge with it. The stimulus uses single-byte packets, stalls mid-packet, errors at the first, middle and last byte, orphan bytes, and packets offered while ready is low.

// File: rtl/gmiitx_pkg.sv
package gmiitx_pkg;

    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned GAP_DEF    = 1;

    // Control flags registered alongside the output byte
    typedef struct packed {
        logic en;
        logic er;
        logic in_frame;
    } ctl_t;

endpackage

// File: rtl/gmiitx_gap.sv
// Idle-gap timer: holds ready low for GAP cycles after a packet closes
module gmiitx_gap #(
    parameter int unsigned GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    localparam int unsigned CW = (GAP < 1) ? 1 : $clog2(GAP + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(GAP);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/gmiitx_errhold.sv
// Sticky error tracker for one frame
module gmiitx_errhold (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic err_in,
    input  logic last,
    output logic err_out
);
    logic hold_d, hold_q;

    always_comb begin
        err_out = beat && (hold_q || err_in);
        hold_d  = hold_q;
        if (beat) begin
            hold_d = err_out && !last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/gmiitx_top.sv
module gmiitx_top
    import gmiitx_pkg::*;
#(
    parameter int unsigned BYTE_W   = BYTE_W_DEF,
    parameter int unsigned IDLE_GAP = GAP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_sop,
    input  logic              s_eop,
    input  logic              s_err,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_en,
    output logic              tx_er
);
    ctl_t              ctl_d, ctl_q;
    logic [BYTE_W-1:0] data_d, data_q;
    logic              accept, framed, close, err_now, gap_ready;

    assign accept = s_valid && gap_ready;
    assign framed = accept && (ctl_q.in_frame || s_sop);
    assign close  = framed && s_eop;

    gmiitx_gap #(.GAP(IDLE_GAP)) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (close),
        .ready (gap_ready)
    );

    gmiitx_errhold i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (framed),
        .err_in  (s_err),
        .last    (s_eop),
        .err_out (err_now)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.en       = framed;
        ctl_d.er       = err_now;
        data_d         = framed ? s_data : '0;
        if (framed) begin
            ctl_d.in_frame = !s_eop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    assign s_ready = gap_ready;
    assign tx_data = data_q;
    assign tx_en   = ctl_q.en;
    assign tx_er   = ctl_q.er;
endmodule

// File: rtl/gmiitx_chk.sv
module gmiitx_chk #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned IDLE_GAP = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic [BYTE_W-1:0] s_data,
    input logic              s_sop,
    input logic              s_eop,
    input logic              s_err,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_en,
    input logic              tx_er
);
    // R6
    er_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |-> tx_en);

    // R7
    er_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |=> (!tx_en || tx_er));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_data == '0));

    // R2
    sop_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_sop) |=> (tx_en && tx_data == $past(s_data)));

    // R4
    gap_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_sop && s_eop) |=> !s_ready);

    // R8
    err_same_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_sop && s_err) |=> tx_er);
endmodule

bind gmiitx_top gmiitx_chk #(.BYTE_W(BYTE_W), .IDLE_GAP(IDLE_GAP)) i_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_err(s_err),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er)
);

// File: tb/test_gmiitx_top.sv
`timescale 1ns/1ps
module test_gmiitx_top;
    localparam int BW  = 8;
    localparam int GAP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_err = 1'b0;
    logic [BW-1:0] s_data = '0;
    logic          s_ready, tx_en, tx_er;
    logic [BW-1:0] tx_data;

    always #2 clk = ~clk;

    gmiitx_top #(.BYTE_W(BW), .IDLE_GAP(GAP)) i_gmiitx_top (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_err(s_err),
        .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er)
    );

    int n_tests = 0, n_fail = 0, cycles = 0;
    string tag = "R1";

    // behavioural model
    bit          m_frame = 0, m_hold = 0;
    int          m_gap = 0;
    bit          e_en = 0, e_er = 0;
    logic [BW-1:0] e_data = '0;

    task automatic check(string rq, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // one clock: compare outputs, then drive and advance the model
    task automatic cyc(bit v, logic [BW-1:0] d, bit sop, bit eop, bit err);
        bit acc, fr, eo;
        @(negedge clk);
        check(tag, "tx_en", int'(tx_en), int'(e_en));
        check(tag, "tx_er", int'(tx_er), int'(e_er));
        check(tag, "tx_data", int'(tx_data), int'(e_data));
        check(tag, "s_ready", int'(s_ready), int'(m_gap == 0));
        if (tx_er && !tx_en) check("R6", "tx_er while idle", 1, 0);
        if (!tx_en) check("R9", "idle data", int'(tx_data), 0);
        s_valid = v; s_data = d; s_sop = sop; s_eop = eop; s_err = err;
        acc = v && (m_gap == 0);
        fr  = acc && (m_frame || sop);
        eo  = fr && (m_hold || err);
        e_en = fr; e_er = eo; e_data = fr ? d : '0;
        if (fr) begin
            m_hold  = eo && !eop;
            m_frame = !eop;
        end
        if (fr && eop) m_gap = GAP;
        else if (m_gap > 0) m_gap--;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
    endtask

    // send a packet; err_at = -1 for none; stall_at inserts one empty cycle before that byte
    task automatic send(int len, int base, int err_at, int stall_at);
        for (int i = 0; i < len; i++) begin
            if (i == stall_at) cyc(0, '0, 0, 0, 0);
            while (m_gap != 0) cyc(1, BW'(base + i), i == 0, i == len - 1, i == err_at);
            cyc(1, BW'(base + i), i == 0, i == len - 1, i == err_at);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", "tx_en in reset", int'(tx_en), 0);
        check("R1", "s_ready in reset", int'(s_ready), 1);
        rst_n = 1'b1;
        tag = "R1"; idle(2);
        // R2 R3: plain packets
        tag = "R3"; send(5, 8'h10, -1, -1); idle(3);
        tag = "R2"; send(1, 8'hA5, -1, -1); idle(3);
        // R4: back-to-back packets, second offered during the gap
        tag = "R4"; send(3, 8'h20, -1, -1); send(2, 8'h30, -1, -1);
        send(1, 8'h40, -1, -1); send(1, 8'h41, -1, -1); idle(3);
        // R5: stalls mid-packet
        tag = "R5"; send(6, 8'h50, -1, 3); send(4, 8'h60, -1, 1); idle(3);
        // R7 R6: error in the middle, held to the end
        tag = "R7"; send(6, 8'h70, 2, -1);
        // R11: next packet clean
        tag = "R11"; send(3, 8'h80, -1, -1); idle(2);
        // R8: error on last byte, on first byte, on a single-byte packet
        tag = "R8"; send(4, 8'h90, 3, -1); send(3, 8'h98, 0, -1);
        send(1, 8'h9F, 0, -1); idle(2);
        // R7: error then a stall, still held after
        tag = "R7"; send(5, 8'hB0, 1, 3); idle(2);
        // R10: orphan bytes without sop, including one with eop
        tag = "R10"; cyc(1, 8'hC1, 0, 0, 0); cyc(1, 8'hC2, 0, 1, 1);
        cyc(1, 8'hC3, 0, 0, 0); idle(1);
        send(2, 8'hD0, -1, -1); idle(3);
        // R9: long idle
        tag = "R9"; idle(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule